// File: doc/BRIEF.md
# Non-Cacheable Region Address Matcher

This block decides whether a physical memory access may be cached. It takes a 32-bit byte address and checks it against a small set of programmable non-cacheable regions and two fixed low-memory windows. If any enabled region or enabled window contains the address, the access is flagged non-cacheable. A separate descriptor of the same format marks a system-management memory region, and that match is reported on its own output.

Each region is given by a 24-bit descriptor. The descriptor holds the start address to 4 KiB granularity and a 4-bit size code. The size is a power of two, and the region covers the aligned block of that size that contains the start address. The two fixed windows are the upper legacy area (A0000h to FFFFFh) and the first 64 KiB above 1 MiB (100000h to 10FFFFh). Each window has its own enable input. The caller presents an address with a valid strobe and reads both decisions one clock later. Both outputs keep their last value until the next strobe.

Top module: `nc_region_check`

## Requirements
- R1: While reset is low at a clock edge, `nc_flag` becomes 1 and `smm_hit` becomes 0. This matches the power-up configuration, in which the whole 4 GiB space starting at address 0 is non-cacheable.
- R2: The outputs are updated at the clock edge where `addr_valid` is high, from the address and controls present at that edge. When `addr_valid` is low, both outputs hold their previous values, whatever happens on the other inputs.
- R3: A descriptor with size code 0 (bits [3:0] of the descriptor) never matches, even when the address equals its start.
- R4: A size code n from 1 to 14 defines a region of 2^(11+n) bytes (4 KiB for 1, doubling up to 32 MiB for 14). The region is aligned to its size. Its start address bits 31..24 are taken from descriptor bits [23:16], bits 23..16 from [15:8], and bits 15..12 from [7:4]. The last byte of the region matches, and the byte just past the region does not.
- R5: Size code 15 matches every address in the 4 GiB space.
- R6: Start bits that lie below the region size are ignored. The region is the aligned block that contains the programmed start.
- R7: When `legacy_upper_nc` is 1, addresses A0000h through FFFFFh are non-cacheable. When it is 0, that window has no effect.
- R8: When `legacy_hma_nc` is 1, addresses 100000h through 10FFFFh are non-cacheable. When it is 0, that window has no effect.
- R9: `nc_flag` is the OR of all enabled region matches and both enabled windows. It is 0 (cacheable) when none of them matches. Region k uses bits [24k+23:24k] of `region_desc`.
- R10: `smm_hit` reports a match against `smm_desc`, using the same format and size rules as the regions. It does not affect `nc_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_valid | input | 1 | Strobe: evaluate `addr` at this edge |
| addr | input | 32 | Physical byte address |
| region_desc | input | 24*NUM_REGIONS | Packed region descriptors; region k in bits [24k+23:24k] |
| legacy_upper_nc | input | 1 | Enable for the A0000h–FFFFFh window |
| legacy_hma_nc | input | 1 | Enable for the 100000h–10FFFFh window |
| smm_desc | input | 24 | System-management region descriptor |
| nc_flag | output | 1 | Registered non-cacheable decision |
| smm_hit | output | 1 | Registered system-management region match |

## Verification
The bench builds the block with the default of four regions. This means every region slot in the packed descriptor bus is written and checked, including the highest one at bits [95:72]. The tests cover the smallest size code (4 KiB), the largest finite code (32 MiB) and the whole-space code 15. They also cover a start address with bits set below the region size, and both edges of each legacy window. Each edge is probed on the byte inside the window and on the byte just outside it.

// File: rtl/ncr_pkg.sv
// Package: shared descriptor type, legacy window bounds and size decoding
// for the non-cacheable region matcher. Assumes a 32-bit physical address
// space and regions at 4 KiB granularity.
package ncr_pkg;

    localparam int ADDR_W = 32;
    localparam int DESC_W = 24;
    localparam int PAGE_SHIFT = 12;

    // Descriptor layout: high start byte, middle start byte, low start nibble, size code.
    typedef struct packed {
        logic [7:0] start_hi;
        logic [7:0] start_mid;
        logic [3:0] start_lo;
        logic [3:0] size_code;
    } ncr_desc_t;

    localparam logic [ADDR_W-1:0] UPPER_LO = 32'h000A_0000;
    localparam logic [ADDR_W-1:0] UPPER_HI = 32'h000F_FFFF;
    localparam logic [ADDR_W-1:0] HMA_LO   = 32'h0010_0000;
    localparam logic [ADDR_W-1:0] HMA_HI   = 32'h0010_FFFF;

    // Rebuild the full start address from a descriptor.
    function automatic logic [ADDR_W-1:0] desc_start(input ncr_desc_t d);
        return {d.start_hi, d.start_mid, d.start_lo, {PAGE_SHIFT{1'b0}}};
    endfunction

    // Compare mask: 1 where address bits must equal start bits.
    // Code 1..14 gives 2^(11+code) bytes; code 15 covers the whole space.
    function automatic logic [ADDR_W-1:0] size_mask(input logic [3:0] code);
        logic [ADDR_W-1:0] m;
        if (code == 4'hF) begin
            m = '0;
        end else begin
            m = ~((32'h1 << (int'(code) + PAGE_SHIFT - 1)) - 32'h1);
        end
        return m;
    endfunction

endpackage

// File: rtl/ncr_region_match.sv
// Module: matches one address against one region descriptor.
// Purely combinational. A size code of 0 disables the region.
// Assumes the descriptor is stable while it is being used.
module ncr_region_match
    import ncr_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    ncr_desc_t         d;
    logic [ADDR_W-1:0] start;
    logic [ADDR_W-1:0] mask;

    // Decode the descriptor and compare the bits above the region size.
    always_comb begin
        d     = ncr_desc_t'(desc);
        start = desc_start(d);
        mask  = size_mask(d.size_code);
        hit   = (d.size_code != 4'h0) && (((addr ^ start) & mask) == '0);
    end

endmodule

// File: rtl/ncr_legacy_window.sv
// Module: checks one address against the two fixed low-memory windows.
// Each window counts only when its enable is set. Combinational.
module ncr_legacy_window
    import ncr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              upper_en,
    input  logic              hma_en,
    output logic              hit
);

    logic in_upper;
    logic in_hma;

    // Inclusive range tests on both windows, gated by their enables.
    always_comb begin
        in_upper = (addr >= UPPER_LO) && (addr <= UPPER_HI);
        in_hma   = (addr >= HMA_LO) && (addr <= HMA_HI);
        hit      = (upper_en && in_upper) || (hma_en && in_hma);
    end

endmodule

// File: rtl/nc_region_check.sv
// Module: cacheability decision for one address per strobe.
// It ORs NUM_REGIONS programmable regions with two fixed windows into nc_flag,
// and matches one system-management region into smm_hit. Both outputs are
// registered one cycle after addr_valid and hold while it is low.
// Reset is synchronous and active low.
module nc_region_check
    import ncr_pkg::*;
#(
    parameter int NUM_REGIONS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          addr_valid,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_REGIONS*DESC_W-1:0] region_desc,
    input  logic                          legacy_upper_nc,
    input  logic                          legacy_hma_nc,
    input  logic [DESC_W-1:0]             smm_desc,
    output logic                          nc_flag,
    output logic                          smm_hit
);

    logic [NUM_REGIONS-1:0] region_hit;
    logic                   legacy_hit;
    logic                   smm_match;
    logic                   nc_next;

    // One matcher per programmable region.
    for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_region
        ncr_region_match u_match (
            .desc (region_desc[k*DESC_W +: DESC_W]),
            .addr (addr),
            .hit  (region_hit[k])
        );
    end

    ncr_legacy_window u_legacy (
        .addr     (addr),
        .upper_en (legacy_upper_nc),
        .hma_en   (legacy_hma_nc),
        .hit      (legacy_hit)
    );

    ncr_region_match u_smm (
        .desc (smm_desc),
        .addr (addr),
        .hit  (smm_match)
    );

    // Any enabled source makes the address non-cacheable.
    always_comb nc_next = (|region_hit) || legacy_hit;

    // Register the decisions on a strobe; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nc_flag <= 1'b1;
            smm_hit <= 1'b0;
        end else if (addr_valid) begin
            nc_flag <= nc_next;
            smm_hit <= smm_match;
        end
    end

endmodule

// File: rtl/ncr_check.sv
// Checker: temporal properties of nc_region_check, observed at its ports.
// It is attached to every instance through the bind below.
module ncr_check
    import ncr_pkg::*;
#(
    parameter int NUM_REGIONS = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          addr_valid,
    input logic [ADDR_W-1:0]             addr,
    input logic [NUM_REGIONS*DESC_W-1:0] region_desc,
    input logic                          legacy_upper_nc,
    input logic                          legacy_hma_nc,
    input logic [DESC_W-1:0]             smm_desc,
    input logic                          nc_flag,
    input logic                          smm_hit
);

    logic any_full;
    logic all_off;

    // Summarise the size codes: is any region whole-space, and are all disabled.
    always_comb begin
        any_full = 1'b0;
        all_off  = 1'b1;
        for (int k = 0; k < NUM_REGIONS; k++) begin
            if (region_desc[k*DESC_W +: 4] == 4'hF) any_full = 1'b1;
            if (region_desc[k*DESC_W +: 4] != 4'h0) all_off = 1'b0;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (nc_flag && !smm_hit));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> ($stable(nc_flag) && $stable(smm_hit)));

    p_full_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && any_full) |=> nc_flag);

    p_upper_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && legacy_upper_nc && addr >= 32'h000A_0000 && addr <= 32'h000F_FFFF)
        |=> nc_flag);

    p_hma_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && legacy_hma_nc && addr[31:16] == 16'h0010) |=> nc_flag);

    p_nothing_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && all_off && !legacy_upper_nc && !legacy_hma_nc) |=> !nc_flag);

    p_smm_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && smm_desc[3:0] == 4'h0) |=> !smm_hit);

endmodule

bind nc_region_check ncr_check #(.NUM_REGIONS(NUM_REGIONS)) u_ncr_check (
    .clk             (clk),
    .rst_n           (rst_n),
    .addr_valid      (addr_valid),
    .addr            (addr),
    .region_desc     (region_desc),
    .legacy_upper_nc (legacy_upper_nc),
    .legacy_hma_nc   (legacy_hma_nc),
    .smm_desc        (smm_desc),
    .nc_flag         (nc_flag),
    .smm_hit         (smm_hit)
);

// File: tb/nc_region_check_tb_top.sv
// Directed bench for nc_region_check. Each scenario task drives its own
// stimulus and checks its own results.
module nc_region_check_tb_top;

    localparam int NR = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            addr_valid = 1'b0;
    logic [31:0]     addr = '0;
    logic [NR*24-1:0] region_desc = '0;
    logic            legacy_upper_nc = 1'b0;
    logic            legacy_hma_nc = 1'b0;
    logic [23:0]     smm_desc = '0;
    logic            nc_flag;
    logic            smm_hit;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    nc_region_check #(.NUM_REGIONS(NR)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .addr_valid      (addr_valid),
        .addr            (addr),
        .region_desc     (region_desc),
        .legacy_upper_nc (legacy_upper_nc),
        .legacy_hma_nc   (legacy_hma_nc),
        .smm_desc        (smm_desc),
        .nc_flag         (nc_flag),
        .smm_hit         (smm_hit)
    );

    function automatic logic [23:0] mk(input logic [31:0] start, input logic [3:0] code);
        return {start[31:12], code};
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Present one address for one strobe, then sample both outputs.
    task automatic probe(input string req, input logic [31:0] a,
                         input logic exp_nc, input logic exp_smm);
        @(negedge clk);
        addr = a;
        addr_valid = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0;
        check(req, nc_flag, exp_nc);
        check(req, smm_hit, exp_smm);
    endtask

    task automatic clear_all();
        region_desc = '0;
        smm_desc = '0;
        legacy_upper_nc = 1'b0;
        legacy_hma_nc = 1'b0;
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        check("R1 nc", nc_flag, 1'b1);
        check("R1 smm", smm_hit, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_disabled();
        clear_all();
        probe("R9 nothing", 32'h1234_5000, 1'b0, 1'b0);
        region_desc[2*24 +: 24] = mk(32'h1234_5000, 4'h0);
        probe("R3 code0", 32'h1234_5000, 1'b0, 1'b0);
    endtask

    task automatic t_sizes();
        clear_all();
        region_desc[1*24 +: 24] = mk(32'h0800_0000, 4'h1);
        probe("R4 4K last", 32'h0800_0FFF, 1'b1, 1'b0);
        probe("R4 4K past", 32'h0800_1000, 1'b0, 1'b0);
        probe("R4 4K below", 32'h07FF_FFFF, 1'b0, 1'b0);
        clear_all();
        region_desc[3*24 +: 24] = mk(32'h0200_0000, 4'hE);
        probe("R4 32M last", 32'h03FF_FFFF, 1'b1, 1'b0);
        probe("R4 32M past", 32'h0400_0000, 1'b0, 1'b0);
    endtask

    task automatic t_unaligned();
        clear_all();
        region_desc[0 +: 24] = mk(32'h0001_3000, 4'h4);
        probe("R6 base", 32'h0001_0000, 1'b1, 1'b0);
        probe("R6 past", 32'h0001_8000, 1'b0, 1'b0);
    endtask

    task automatic t_full();
        clear_all();
        region_desc[3*24 +: 24] = mk(32'hAB12_3000, 4'hF);
        probe("R5 top", 32'hFFFF_FFFC, 1'b1, 1'b0);
        probe("R5 zero", 32'h0000_0000, 1'b1, 1'b0);
    endtask

    task automatic t_upper();
        clear_all();
        probe("R7 off", 32'h000A_0000, 1'b0, 1'b0);
        legacy_upper_nc = 1'b1;
        probe("R7 low", 32'h000A_0000, 1'b1, 1'b0);
        probe("R7 below", 32'h0009_FFFF, 1'b0, 1'b0);
        probe("R7 high", 32'h000F_FFFF, 1'b1, 1'b0);
        probe("R7 above", 32'h0010_0000, 1'b0, 1'b0);
    endtask

    task automatic t_hma();
        clear_all();
        probe("R8 off", 32'h0010_0000, 1'b0, 1'b0);
        legacy_hma_nc = 1'b1;
        probe("R8 low", 32'h0010_0000, 1'b1, 1'b0);
        probe("R8 high", 32'h0010_FFFF, 1'b1, 1'b0);
        probe("R8 above", 32'h0011_0000, 1'b0, 1'b0);
        probe("R8 below", 32'h000F_FFFF, 1'b0, 1'b0);
    endtask

    task automatic t_combined();
        clear_all();
        legacy_upper_nc = 1'b1;
        region_desc[2*24 +: 24] = mk(32'h000A_0000, 4'h6);
        probe("R9 overlap", 32'h000B_0000, 1'b1, 1'b0);
        probe("R9 region only", 32'h0009_0000, 1'b0, 1'b0);
        region_desc[0 +: 24] = mk(32'h0009_0000, 4'h1);
        probe("R9 second region", 32'h0009_0FFF, 1'b1, 1'b0);
    endtask

    task automatic t_hold();
        clear_all();
        legacy_hma_nc = 1'b1;
        probe("R2 set", 32'h0010_1000, 1'b1, 1'b0);
        @(negedge clk);
        addr = 32'h5000_0000;
        legacy_hma_nc = 1'b0;
        smm_desc = mk(32'h5000_0000, 4'h1);
        repeat (3) @(negedge clk);
        check("R2 hold nc", nc_flag, 1'b1);
        check("R2 hold smm", smm_hit, 1'b0);
        probe("R2 update", 32'h5000_0000, 1'b0, 1'b1);
    endtask

    task automatic t_smm();
        clear_all();
        smm_desc = mk(32'h0003_0000, 4'h5);
        probe("R10 last", 32'h0003_FFFF, 1'b0, 1'b1);
        probe("R10 past", 32'h0004_0000, 1'b0, 1'b0);
        region_desc[1*24 +: 24] = mk(32'h0003_0000, 4'h1);
        probe("R10 both", 32'h0003_0010, 1'b1, 1'b1);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_sizes();
        t_unaligned();
        t_full();
        t_upper();
        t_hma();
        t_combined();
        t_hold();
        t_smm();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule